// File: doc/BRIEF.md
# Dual-Frequency Quad-Phase NCO Core

This block is the digital heart of a direct digital synthesizer. A 32-bit phase accumulator advances by a tuning word once per master clock cycle, so the output frequency is the tuning word times the clock frequency divided by 2^32. The top 12 bits of the accumulator, plus a 12-bit phase offset, address a sine lookup. The lookup returns a 10-bit amplitude code in offset binary form, ready for an external converter.

Two tuning words and four phase offsets are presented as ports. A frequency select pin chooses the tuning word and a two-bit phase select chooses the offset. Both selects are sampled on the rising clock edge, so frequency and phase modulation are done by toggling pins. A sleep input freezes the phase and parks the output at mid-scale. Reset clears the accumulator.

Top module: `nco_core`

## Requirements
- R1: While awake, the accumulator adds the selected tuning word on every rising edge and wraps modulo 2^32. Tuning word 0 is selected when `freq_sel_i` is 0, and tuning word 1 when it is 1.
- R2: `freq_sel_i` is registered on the rising edge E. The accumulator adds the newly chosen word at edge E+1, and the output reflects it from edge E+3.
- R3: The phase select `phase_sel_i[1:0]` picks the offset: 2'b00 selects `phase_ofs0_i`, 2'b01 selects `phase_ofs1_i`, 2'b10 selects `phase_ofs2_i` and 2'b11 selects `phase_ofs3_i`. The select is registered on the rising edge.
- R4: The lookup phase is accumulator bits [31:20] plus the selected offset, modulo 4096. It is registered one edge after the select register.
- R5: For lookup phase p, the output code is 512 ± m, where m = round(511·|sin(2π(p+0.5)/4096)|). The sign follows sin, and rounding is half away from zero. Every code therefore lies in 1..1023.
- R6: A change of `phase_sel_i` sampled at edge E appears on `amp_o` after edge E+2. A change of the tuning words or offsets has the same fixed pipeline depth behind the accumulator.
- R7: If `sleep_i` is high at an edge, the accumulator holds its value and `amp_o` becomes 512 at that edge. When sleep is released, the phase continues from the held value.
- R8: While `rst_n` is low, the accumulator and both selects are cleared and `amp_o` is 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Freeze phase, output mid-scale |
| freq_sel_i | input | 1 | Tuning word select |
| phase_sel_i | input | 2 | Phase offset select |
| ftw0_i | input | 32 | Tuning word 0 |
| ftw1_i | input | 32 | Tuning word 1 |
| phase_ofs0_i | input | 12 | Phase offset 0 |
| phase_ofs1_i | input | 12 | Phase offset 1 |
| phase_ofs2_i | input | 12 | Phase offset 2 |
| phase_ofs3_i | input | 12 | Phase offset 3 |
| amp_o | output | 10 | Offset-binary sine amplitude |

## Verification
On every cycle, the bound checker enforces several rules: the accumulator step for each select value, the hold during sleep, the mid-scale output after a sleep edge, the offset addition with its select delay, and the legal code range. The exact amplitude values, the rounding of the quarter-wave table and its folding across quadrants can only be shown by the bench. So can the end-to-end latency after a select change and the resumption of phase after sleep. The bench shows them by comparing every output sample against an independent cycle model built on a floating-point sine.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int unsigned ACC_W_DEF = 32;
    localparam int unsigned PH_W_DEF  = 12;
    localparam int unsigned AMP_W_DEF = 10;
    localparam int unsigned N_OFS     = 4;
    localparam real         PI_R      = 3.14159265358979323846;

    typedef enum logic [1:0] {
        QUAD_RISE  = 2'd0,
        QUAD_FALL  = 2'd1,
        QUAD_NRISE = 2'd2,
        QUAD_NFALL = 2'd3
    } quadrant_e;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int unsigned ACC_W = nco_pkg::ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             fsel_i,
    input  logic [ACC_W-1:0] ftw0_i,
    input  logic [ACC_W-1:0] ftw1_i,
    output logic [ACC_W-1:0] acc_o
);
    typedef struct packed {
        logic             fsel;
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fsel = fsel_i;
        if (!sleep_i) begin
            st_d.acc = st_q.acc + (st_q.fsel ? ftw1_i : ftw0_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;
endmodule

// File: rtl/nco_offset_add.sv
module nco_offset_add #(
    parameter int unsigned PH_W  = nco_pkg::PH_W_DEF,
    parameter int unsigned N_OFS = nco_pkg::N_OFS,
    localparam int unsigned SEL_W = $clog2(N_OFS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SEL_W-1:0]            psel_i,
    input  logic [N_OFS-1:0][PH_W-1:0]  ofs_i,
    input  logic [PH_W-1:0]             acc_top_i,
    output logic [PH_W-1:0]             phase_o
);
    typedef struct packed {
        logic [SEL_W-1:0] psel;
        logic [PH_W-1:0]  phase;
    } ofs_state_t;

    ofs_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.psel  = psel_i;
        st_d.phase = acc_top_i + ofs_i[st_q.psel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
    parameter int unsigned PH_W  = nco_pkg::PH_W_DEF,
    parameter int unsigned AMP_W = nco_pkg::AMP_W_DEF,
    localparam int unsigned QTR_W = PH_W - 2,
    localparam int unsigned QTR_N = 1 << QTR_W,
    localparam int unsigned MAG_W = AMP_W - 1,
    localparam int unsigned MID   = 1 << MAG_W,
    localparam int unsigned PEAK  = MID - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic [PH_W-1:0]  phase_i,
    output logic [AMP_W-1:0] amp_o
);
    import nco_pkg::*;

    typedef logic [MAG_W-1:0] mag_tab_t [QTR_N];

    function automatic mag_tab_t build_tab();
        mag_tab_t t;
        for (int i = 0; i < QTR_N; i++) begin
            real x, term, sum;
            x    = (real'(i) + 0.5) * PI_R / (2.0 * real'(QTR_N));
            term = x;
            sum  = x;
            for (int k = 1; k < 10; k++) begin
                term = -term * x * x / (real'(2 * k) * real'(2 * k + 1));
                sum  = sum + term;
            end
            t[i] = MAG_W'($rtoi(sum * real'(PEAK) + 0.5));
        end
        return t;
    endfunction

    localparam mag_tab_t TAB = build_tab();

    typedef struct packed {
        logic [AMP_W-1:0] amp;
    } lut_state_t;

    lut_state_t      st_d, st_q;
    quadrant_e       quad;
    logic [QTR_W-1:0] idx;
    logic [MAG_W-1:0] mag;

    always_comb begin
        quad = quadrant_e'(phase_i[PH_W-1 -: 2]);
        idx  = phase_i[QTR_W-1:0];
        if (quad == QUAD_FALL || quad == QUAD_NFALL) begin
            idx = ~idx;
        end
        mag  = TAB[idx];
        st_d = st_q;
        if (sleep_i) begin
            st_d.amp = AMP_W'(MID);
        end else if (quad == QUAD_RISE || quad == QUAD_FALL) begin
            st_d.amp = AMP_W'(MID) + AMP_W'(mag);
        end else begin
            st_d.amp = AMP_W'(MID) - AMP_W'(mag);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.amp <= AMP_W'(MID);
        end else begin
            st_q <= st_d;
        end
    end

    assign amp_o = st_q.amp;
endmodule

// File: rtl/nco_core.sv
module nco_core #(
    parameter int unsigned ACC_W = nco_pkg::ACC_W_DEF,
    parameter int unsigned PH_W  = nco_pkg::PH_W_DEF,
    parameter int unsigned AMP_W = nco_pkg::AMP_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             freq_sel_i,
    input  logic [1:0]       phase_sel_i,
    input  logic [ACC_W-1:0] ftw0_i,
    input  logic [ACC_W-1:0] ftw1_i,
    input  logic [PH_W-1:0]  phase_ofs0_i,
    input  logic [PH_W-1:0]  phase_ofs1_i,
    input  logic [PH_W-1:0]  phase_ofs2_i,
    input  logic [PH_W-1:0]  phase_ofs3_i,
    output logic [AMP_W-1:0] amp_o
);
    logic [ACC_W-1:0]                    acc_w;
    logic [PH_W-1:0]                     phase_w;
    logic [nco_pkg::N_OFS-1:0][PH_W-1:0] ofs_w;

    assign ofs_w = {phase_ofs3_i, phase_ofs2_i, phase_ofs1_i, phase_ofs0_i};

    nco_phase_acc #(.ACC_W(ACC_W)) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep_i(sleep_i),
        .fsel_i (freq_sel_i),
        .ftw0_i (ftw0_i),
        .ftw1_i (ftw1_i),
        .acc_o  (acc_w)
    );

    nco_offset_add #(.PH_W(PH_W), .N_OFS(nco_pkg::N_OFS)) ofs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel_i   (phase_sel_i),
        .ofs_i    (ofs_w),
        .acc_top_i(acc_w[ACC_W-1 -: PH_W]),
        .phase_o  (phase_w)
    );

    nco_sine_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) lut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep_i(sleep_i),
        .phase_i(phase_w),
        .amp_o  (amp_o)
    );
endmodule

// File: rtl/nco_core_chk.sv
module nco_core_chk #(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned PH_W  = 12,
    parameter int unsigned AMP_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_i,
    input logic             freq_sel_i,
    input logic [1:0]       phase_sel_i,
    input logic [ACC_W-1:0] ftw0_i,
    input logic [ACC_W-1:0] ftw1_i,
    input logic [PH_W-1:0]  phase_ofs0_i,
    input logic [PH_W-1:0]  phase_ofs1_i,
    input logic [PH_W-1:0]  phase_ofs2_i,
    input logic [PH_W-1:0]  phase_ofs3_i,
    input logic [AMP_W-1:0] amp_o,
    input logic [ACC_W-1:0] acc_w,
    input logic [PH_W-1:0]  phase_w
);
    localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

    logic [1:0]      warm_q;
    logic [1:0]      psel_d1_q;
    logic [PH_W-1:0] cur_ofs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q    <= '0;
            psel_d1_q <= '0;
        end else begin
            if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
            psel_d1_q <= phase_sel_i;
        end
    end

    always_comb begin
        case (psel_d1_q)
            2'd0:    cur_ofs = phase_ofs0_i;
            2'd1:    cur_ofs = phase_ofs1_i;
            2'd2:    cur_ofs = phase_ofs2_i;
            default: cur_ofs = phase_ofs3_i;
        endcase
    end

    assert_step_word0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && !sleep_i && !$past(freq_sel_i)) |=> acc_w == $past(acc_w) + $past(ftw0_i));

    assert_step_word1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && !sleep_i && $past(freq_sel_i)) |=> acc_w == $past(acc_w) + $past(ftw1_i));

    assert_offset_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |=> phase_w == PH_W'($past(acc_w[ACC_W-1 -: PH_W]) + $past(cur_ofs)));

    assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> $stable(acc_w));

    assert_sleep_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> amp_o == MID);

    assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        amp_o != '0);
endmodule

bind nco_core nco_core_chk #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .freq_sel_i  (freq_sel_i),
    .phase_sel_i (phase_sel_i),
    .ftw0_i      (ftw0_i),
    .ftw1_i      (ftw1_i),
    .phase_ofs0_i(phase_ofs0_i),
    .phase_ofs1_i(phase_ofs1_i),
    .phase_ofs2_i(phase_ofs2_i),
    .phase_ofs3_i(phase_ofs3_i),
    .amp_o       (amp_o),
    .acc_w       (acc_w),
    .phase_w     (phase_w)
);

// File: tb/nco_core_tb_top.sv
`timescale 1ns/1ps
module nco_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_i = 1'b0;
    logic        freq_sel_i = 1'b0;
    logic [1:0]  phase_sel_i = 2'd0;
    logic [31:0] ftw0_i = '0;
    logic [31:0] ftw1_i = '0;
    logic [11:0] ofs0 = '0, ofs1 = '0, ofs2 = '0, ofs3 = '0;
    logic [9:0]  amp_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    nco_core dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .freq_sel_i(freq_sel_i),
        .phase_sel_i(phase_sel_i), .ftw0_i(ftw0_i), .ftw1_i(ftw1_i),
        .phase_ofs0_i(ofs0), .phase_ofs1_i(ofs1), .phase_ofs2_i(ofs2),
        .phase_ofs3_i(ofs3), .amp_o(amp_o)
    );

    // Expected code from R5
    function automatic logic [9:0] sine_ref(input logic [11:0] p);
        real a, s, m;
        int  mag;
        a = 2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 4096.0;
        s = $sin(a);
        m = (s < 0.0) ? -s : s;
        mag = $rtoi(m * 511.0 + 0.5);
        return (s < 0.0) ? 10'(512 - mag) : 10'(512 + mag);
    endfunction

    function automatic logic [11:0] ofs_of(input logic [1:0] s);
        case (s)
            2'd0: return ofs0;
            2'd1: return ofs1;
            2'd2: return ofs2;
            default: return ofs3;
        endcase
    endfunction

    // Cycle model from R1..R8 timing
    logic [31:0] m_acc = '0;
    logic        m_fs = 1'b0;
    logic [1:0]  m_ps = '0;
    logic [11:0] m_ph = '0;
    logic [9:0]  m_amp = 10'd512;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; m_fs = 1'b0; m_ps = '0; m_ph = '0; m_amp = 10'd512;
        end else begin
            m_amp = sleep_i ? 10'd512 : sine_ref(m_ph);
            m_ph  = m_acc[31:20] + ofs_of(m_ps);
            if (!sleep_i) m_acc = m_acc + (m_fs ? ftw1_i : ftw0_i);
            m_fs = freq_sel_i;
            m_ps = phase_sel_i;
        end
    end

    task automatic check(input string tag, input logic [9:0] exp_v);
        n_checks++;
        if (amp_o !== exp_v) begin
            n_fail++;
            $display("FAIL %s: amp_o=%0d expected=%0d at %0t", tag, amp_o, exp_v, $time);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag, m_amp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset mid-scale", 10'd512);
        rst_n = 1'b1;
    endtask

    task automatic t_phase_sel();
        ftw0_i = '0; ftw1_i = '0;
        ofs0 = 12'd100; ofs1 = 12'd1500; ofs2 = 12'd2900; ofs3 = 12'd3900;
        for (int s = 0; s < 4; s++) begin
            phase_sel_i = 2'(s);
            @(negedge clk); @(negedge clk);
            check("R6 latency two", m_amp);
            @(negedge clk);
            check("R3 offset select", sine_ref(ofs_of(2'(s))));
        end
        run(8, "R3");
    endtask

    task automatic t_freq_sel();
        ftw0_i = 32'h0010_0000; ftw1_i = 32'h547A_E148;
        ofs0 = 12'd0; phase_sel_i = 2'd0;
        run(40, "R1");
        freq_sel_i = 1'b1;
        run(60, "R2");
        freq_sel_i = 1'b0;
        run(20, "R2");
    endtask

    task automatic t_wrap();
        ftw0_i = 32'hFFF0_0000; ofs0 = 12'd4095;
        run(50, "R4 wrap");
        ftw0_i = 32'h8000_0001;
        run(30, "R1 wrap");
    endtask

    task automatic t_sweep();
        ftw0_i = 32'h0010_0000; ofs0 = 12'd0;
        run(4200, "R5");
    endtask

    task automatic t_sleep();
        ftw0_i = 32'h0123_4567;
        run(10, "R7");
        sleep_i = 1'b1;
        @(negedge clk);
        check("R7 mid-scale", 10'd512);
        run(10, "R7 hold");
        sleep_i = 1'b0;
        run(20, "R7 resume");
    endtask

    initial begin
        t_reset();
        t_phase_sel();
        t_freq_sel();
        t_wrap();
        t_sweep();
        t_sleep();
        ftw0_i = 32'h0200_0000;
        run(10, "R1");
        t_reset();
        run(10, "R8 restart");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule